// File: doc/BRIEF.md
# Status Readback Queue with AXI-Lite Read Port

This block collects 64-bit completion status words from internal logic and lets a host collect them by polling. A producer presents a word on a data input together with a one-cycle valid strobe. The word goes into a small synchronous queue. The producer never waits: when the queue has no free slot, the word is discarded and nothing reports the loss. This is acceptable because a later status word carries the same information.

The host side is the read half of an AXI-Lite slave, with a 12-bit address and 64-bit data. Each accepted read-address beat removes the oldest queued word and copies it into a read-data register. The block then holds the read response until the host accepts it. The address value plays no part in choosing the data. The host can only issue a read when at least one word is queued and no earlier response is still waiting. An asynchronous active-low reset is released on a clock edge inside the block.

Top module: `axil_status_readback`

## Requirements
- R1: While reset is active, and in the cycle after reset release completes, `s_rvalid` and `s_arready` are low and the queue holds no words.
- R2: A word presented with `push_valid_i` high is stored when the queue has room. `s_arready` goes high in the cycle after the first push into an empty queue, unless a response is outstanding.
- R3: When the queue already holds `DEPTH` words and no read is taken in the same cycle, a push is discarded. The stored words are unchanged and the queue never holds more than `DEPTH` words.
- R4: On a cycle where `s_arvalid` and `s_arready` are both high, the oldest word is removed from the queue. In the next cycle `s_rvalid` is high and `s_rdata` equals that word.
- R5: While `s_rvalid` is high and `s_rready` is low, `s_rvalid` stays high and `s_rdata` keeps its value. After a cycle with `s_rvalid` and `s_rready` both high, `s_rvalid` is low.
- R6: `s_arready` is low whenever the queue is empty, and low whenever `s_rvalid` is high.
- R7: Words are returned to the host in the order they were pushed.
- R8: `s_rresp` always reads 2'b00 (OKAY), and the value on `s_araddr` has no effect on the returned data.
- R9: If a push and a read happen in the same cycle while the queue is full, the pushed word is kept and is returned after the words that were already queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid_i | input | 1 | Status word present this cycle |
| push_data_i | input | 64 | Status word from internal logic |
| s_araddr | input | 12 | Read address, not used for data selection |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 64 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Host accepts read data |

## Verification
A push that lands on a clock edge shows up as `s_arready` just after that same edge, because the ready signal is decoded from the registered fill state. An address handshake on an edge makes `s_rvalid` and `s_rdata` valid just after that edge. A data handshake clears `s_rvalid` just after its edge. Reset release takes two edges to reach the internal logic. The bench changes inputs and samples outputs 1 ns after each rising edge, so every check sees the state produced by exactly one edge. Each check is placed at the edge count worked out above.

// File: rtl/stat_rb_pkg.sv
`timescale 1ns/1ps
package stat_rb_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_BUSY = 1'b1
  } rd_state_t;
endpackage

// File: rtl/stat_rst_sync.sv
`timescale 1ns/1ps
module stat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/stat_fifo.sv
`timescale 1ns/1ps
module stat_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              accept, take;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign head_o  = mem[rd_ptr_q];

  // a push into a full queue survives only when a slot frees up this cycle
  assign take   = rd_en_i && !empty_o;
  assign accept = wr_en_i && (!full_o || take);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (accept) wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    if (take)   rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    case ({accept, take})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage carries no reset; the write enable is the clock enable
  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr_q] <= wr_data_i;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (full_o && wr_en_i && !rd_en_i) |=> (full_o && $stable(rd_ptr_q) && $stable(wr_ptr_q)));

  assert_push_on_pop_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (full_o && wr_en_i && rd_en_i) |=> full_o);

  assert_no_read_empty_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_en_i |-> !empty_o);
endmodule

// File: rtl/stat_rd_port.sv
`timescale 1ns/1ps
module stat_rd_port
  import stat_rb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              q_empty_i,
  input  logic [DATA_W-1:0] q_head_i,
  output logic              q_pop_o,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i
);
  rd_state_t         state_q, state_d;
  logic [DATA_W-1:0] rdata_q;
  logic              load_en;

  assign arready_o = (state_q == RD_IDLE) && !q_empty_i;
  assign load_en   = arvalid_i && arready_o;
  assign q_pop_o   = load_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RD_IDLE: if (load_en)  state_d = RD_BUSY;
      RD_BUSY: if (rready_i) state_d = RD_IDLE;
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= RD_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (load_en) rdata_q <= q_head_i;
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = (state_q == RD_BUSY);
  assign rresp_o  = RESP_OKAY;

  assert_load_resp_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (arvalid_i && arready_o) |=> (rvalid_o && rdata_o == $past(q_head_i)));

  assert_resp_hold_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o)));

  assert_resp_done_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (rvalid_o && rready_i) |=> !rvalid_o);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (arvalid_i && !arready_o) |=> $stable(araddr_i));
endmodule

// File: rtl/axil_status_readback.sv
`timescale 1ns/1ps
module axil_status_readback #(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 64,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready
);
  logic              rst_ni;
  logic              q_empty, q_full, q_pop;
  logic [DATA_W-1:0] q_head;

  stat_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_ni)
  );

  stat_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (push_valid_i),
    .wr_data_i (push_data_i),
    .rd_en_i   (q_pop),
    .head_o    (q_head),
    .empty_o   (q_empty),
    .full_o    (q_full)
  );

  stat_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .q_empty_i (q_empty),
    .q_head_i  (q_head),
    .q_pop_o   (q_pop),
    .araddr_i  (s_araddr),
    .arvalid_i (s_arvalid),
    .arready_o (s_arready),
    .rdata_o   (s_rdata),
    .rresp_o   (s_rresp),
    .rvalid_o  (s_rvalid),
    .rready_i  (s_rready)
  );

  assert_ready_gate_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (s_rvalid || q_empty) |-> !s_arready);

  assert_ready_after_push_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (q_empty && push_valid_i && !s_rvalid) |=> s_arready);

  assert_full_has_data_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    q_full |-> !q_empty);
endmodule

// File: tb/sim_axil_status_readback.sv
`timescale 1ns/1ps
module sim_axil_status_readback;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid_i;
  logic [63:0] push_data_i;
  logic [11:0] s_araddr;
  logic        s_arvalid;
  logic        s_arready;
  logic [63:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  axil_status_readback #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .push_valid_i(push_valid_i), .push_data_i(push_data_i),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word(int k);
    return 64'hA5C3_0000_0000_0000 | 64'(k * 64'h1_0001);
  endfunction

  task automatic push(logic [63:0] d);
    push_valid_i = 1'b1;
    push_data_i  = d;
    step();
    push_valid_i = 1'b0;
  endtask

  // one full read with a checked response; hold_cycles delays the acceptance
  task automatic read_expect(string req, logic [63:0] exp, logic [11:0] addr, int hold_cycles);
    s_araddr  = addr;
    s_arvalid = 1'b1;
    for (int i = 0; i < 20 && !s_arready; i++) step();
    check(req, {63'd0, s_arready}, 64'd1);
    step();
    s_arvalid = 1'b0;
    check("R4 rvalid", {63'd0, s_rvalid}, 64'd1);
    check(req, s_rdata, exp);
    check("R8 rresp", {62'd0, s_rresp}, 64'd0);
    for (int i = 0; i < hold_cycles; i++) begin
      s_arvalid = 1'b1;
      step();
      check("R5 hold valid", {63'd0, s_rvalid}, 64'd1);
      check("R5 hold data", s_rdata, exp);
      check("R6 ready low", {63'd0, s_arready}, 64'd0);
    end
    s_arvalid = 1'b0;
    s_rready  = 1'b1;
    step();
    s_rready  = 1'b0;
    check("R5 rvalid clear", {63'd0, s_rvalid}, 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    push_valid_i = 1'b0; push_data_i = '0;
    s_araddr = '0; s_arvalid = 1'b0; s_rready = 1'b0;
    step(); step();
    check("R1 rvalid in reset", {63'd0, s_rvalid}, 64'd0);
    check("R1 arready in reset", {63'd0, s_arready}, 64'd0);
    rst_n = 1'b1;
    step(); step(); step();
    check("R1 rvalid after reset", {63'd0, s_rvalid}, 64'd0);
    check("R1 arready after reset", {63'd0, s_arready}, 64'd0);
  endtask

  task automatic t_single();
    push(word(1));
    check("R2 arready after push", {63'd0, s_arready}, 64'd1);
    read_expect("R4 single", word(1), 12'h000, 0);
    check("R6 empty ready", {63'd0, s_arready}, 64'd0);
  endtask

  task automatic t_order_hold();
    for (int k = 10; k < 14; k++) push(word(k));
    read_expect("R7 order 0", word(10), 12'h008, 3);
    read_expect("R8 addr ignored", word(11), 12'hFFF, 0);
    read_expect("R7 order 2", word(12), 12'h123, 1);
    read_expect("R7 order 3", word(13), 12'h000, 0);
    check("R6 empty after drain", {63'd0, s_arready}, 64'd0);
  endtask

  task automatic t_drop();
    for (int k = 20; k < 20 + DEPTH + 3; k++) push(word(k));
    for (int k = 0; k < DEPTH; k++) read_expect("R3 kept", word(20 + k), 12'h000, 0);
    check("R3 extra dropped", {63'd0, s_arready}, 64'd0);
  endtask

  task automatic t_full_swap();
    for (int k = 40; k < 40 + DEPTH; k++) push(word(k));
    s_arvalid = 1'b1;
    push_valid_i = 1'b1;
    push_data_i = word(99);
    check("R9 ready when full", {63'd0, s_arready}, 64'd1);
    step();
    s_arvalid = 1'b0;
    push_valid_i = 1'b0;
    check("R9 head", s_rdata, word(40));
    s_rready = 1'b1;
    step();
    s_rready = 1'b0;
    for (int k = 1; k < DEPTH; k++) read_expect("R9 rest", word(40 + k), 12'h000, 0);
    read_expect("R9 pushed kept", word(99), 12'h000, 0);
    check("R9 empty after", {63'd0, s_arready}, 64'd0);
  endtask

  task automatic t_push_while_busy();
    push(word(70));
    s_arvalid = 1'b1;
    step();
    s_arvalid = 1'b0;
    push(word(71));
    check("R6 ready low while busy", {63'd0, s_arready}, 64'd0);
    s_rready = 1'b1;
    step();
    s_rready = 1'b0;
    check("R2 ready after resp", {63'd0, s_arready}, 64'd1);
    read_expect("R7 after busy", word(71), 12'h000, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_order_hold();
    t_drop();
    t_full_swap();
    t_push_while_busy();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule